// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds wall-clock time and calendar date in seven packed-BCD byte registers: seconds, minutes, hours, date, month, day of week and two-digit year. A synchronous one-cycle tick input advances the seconds register. Each register rolls over into the next one, following the calendar rules: month lengths, a leap February, and either a 12-hour clock with an AM/PM flag or a 24-hour clock.

A host loads any register through a single-cycle write port and reads any register through a combinational read port. Two control bits sit inside the time registers. Bit 7 of the seconds byte freezes the whole counter while set. Bit 7 of the hours byte picks the hour format, and bit 5 of the hours byte is the PM flag in 12-hour mode.

Top module: `bcd_rtc`

## Requirements
- R1: After rst_ni is asserted low, the registers read: seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, day of week 0x01, year 0x00.
- R2: A write with wr_en_i high stores wr_data_i at the next clock edge, ANDed with the register's mask. The masks are: address 0 (seconds) 0xFF, 1 (minutes) 0x7F, 2 (hours) 0xBF, 3 (date) 0x3F, 4 (month) 0x1F, 5 (day of week) 0x07, 6 (year) 0xFF. A write to address 7 changes nothing. rd_data_o returns the byte at rd_addr_i in the same cycle, and address 7 reads 0x00.
- R3: An accepted tick increments seconds in BCD. Seconds 59 becomes 00 and increments minutes, and minutes 59 becomes 00 and carries into the hours register.
- R4: While seconds bit 7 is 1, ticks change no register. While it is 0, ticks are accepted.
- R5: In 24-hour mode (hours bit 7 = 0, bits 5:0 hold hours 00 to 23), an hour carry from 23 gives 00 and advances the date.
- R6: In 12-hour mode (hours bit 7 = 1, bit 5 = PM, bits 4:0 hold hours 01 to 12), hour 11 becomes 12 and inverts bit 5, and hour 12 becomes 01. The date advances only on the step from 11 PM to 12 AM.
- R7: On a date advance, a date at or past the last day of the current month becomes 01 and the month increments. April, June, September and November have 30 days, and the other months have 31. February has 29 days when the year value is divisible by 4, and 28 days otherwise.
- R8: Every date advance also steps the day of week from 07 to 01, and from any other value to that value plus one. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R9: In a cycle with wr_en_i high, a tick has no effect on any register.
- R10: With tick_i and wr_en_i both low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance enable, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address for the write |
| wr_data_i | input | 8 | Write data, packed BCD |
| rd_addr_i | input | 3 | Register address for the read |
| rd_data_o | output | 8 | Read data for rd_addr_i |

## Verification
The counter is tried from loaded states next to every carry boundary: seconds and minutes at 59, hour 23 in 24-hour mode, hours 11 and 12 in both halves of the day in 12-hour mode, and ends of 30-day, 31-day, leap and non-leap February, and year 99. Each of these boundaries shows whether the carry chain stops or propagates at the right stage. Random loads biased toward 55–59 seconds and minutes are mixed with ticks, idle cycles, halt-bit writes and writes coinciding with ticks. These separate the halt and write-priority rules from normal counting. Every step compares all eight read addresses with a bench model that counts in binary and converts to BCD.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd3;
  localparam logic [ADDR_W-1:0] A_MON  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DOW  = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

  localparam logic [DATA_W-1:0] RST_SEC  = 8'h00;
  localparam logic [DATA_W-1:0] RST_MIN  = 8'h00;
  localparam logic [DATA_W-1:0] RST_HOUR = 8'h00;
  localparam logic [DATA_W-1:0] RST_DATE = 8'h01;
  localparam logic [DATA_W-1:0] RST_MON  = 8'h01;
  localparam logic [DATA_W-1:0] RST_DOW  = 8'h01;
  localparam logic [DATA_W-1:0] RST_YEAR = 8'h00;

  function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  function automatic logic [DATA_W-1:0] reg_mask(input logic [ADDR_W-1:0] a);
    case (a)
      A_SEC:   return 8'hFF;
      A_MIN:   return 8'h7F;
      A_HOUR:  return 8'hBF;
      A_DATE:  return 8'h3F;
      A_MON:   return 8'h1F;
      A_DOW:   return 8'h07;
      A_YEAR:  return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_hour_step.sv
module bcd_rtc_hour_step
  import bcd_rtc_pkg::*;
(
  input  logic [DATA_W-1:0] hour_i,
  output logic [DATA_W-1:0] hour_o,
  output logic              day_carry_o
);
  logic              mode12;
  logic              pm;
  logic [DATA_W-1:0] h12, h24, h12_inc, h24_inc;

  assign mode12  = hour_i[7];
  assign pm      = hour_i[5];
  assign h12     = {3'b000, hour_i[4:0]};
  assign h24     = {2'b00, hour_i[5:0]};
  assign h12_inc = bcd_inc(h12);
  assign h24_inc = bcd_inc(h24);

  always_comb begin
    hour_o      = '0;
    day_carry_o = 1'b0;
    if (mode12) begin
      if (h12 == 8'h11) begin
        hour_o      = {1'b1, 1'b0, ~pm, 5'h12};
        day_carry_o = pm;  // 11 PM -> 12 AM starts a new day
      end else if (h12 == 8'h12) begin
        hour_o = {1'b1, 1'b0, pm, 5'h01};
      end else begin
        hour_o = {1'b1, 1'b0, pm, h12_inc[4:0]};
      end
    end else begin
      if (h24 == 8'h23) begin
        hour_o      = 8'h00;
        day_carry_o = 1'b1;
      end else begin
        hour_o = {2'b00, h24_inc[5:0]};
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_month_len.sv
module bcd_rtc_month_len
  import bcd_rtc_pkg::*;
(
  input  logic [DATA_W-1:0] month_i,
  input  logic [DATA_W-1:0] year_i,
  output logic [DATA_W-1:0] last_date_o
);
  logic [3:0] mod_sum;
  logic       leap;

  // 10*t + u == 2*t + u (mod 4); only the low bit of t matters
  assign mod_sum = {2'b00, year_i[4], 1'b0} + year_i[3:0];
  assign leap    = (mod_sum[1:0] == 2'b00);

  always_comb begin
    case (month_i)
      8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
      default:                    last_date_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] sec_q, min_q, hour_q, date_q, mon_q, dow_q, year_q;
  logic [DATA_W-1:0] hour_nxt, last_date, wr_val;
  logic              adv, c_min, c_hour, c_day, c_mon, c_year, hour_carry;

  bcd_rtc_hour_step u_hour (
    .hour_i      (hour_q),
    .hour_o      (hour_nxt),
    .day_carry_o (hour_carry)
  );

  bcd_rtc_month_len u_mlen (
    .month_i     (mon_q),
    .year_i      (year_q),
    .last_date_o (last_date)
  );

  assign adv    = tick_i & ~wr_en_i & ~sec_q[7];
  assign c_min  = adv & (sec_q[6:0] == 7'h59);
  assign c_hour = c_min & (min_q == 8'h59);
  assign c_day  = c_hour & hour_carry;
  assign c_mon  = c_day & (date_q >= last_date);
  assign c_year = c_mon & (mon_q == 8'h12);
  assign wr_val = wr_data_i & reg_mask(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= RST_SEC;
      min_q  <= RST_MIN;
      hour_q <= RST_HOUR;
      date_q <= RST_DATE;
      mon_q  <= RST_MON;
      dow_q  <= RST_DOW;
      year_q <= RST_YEAR;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_SEC:   sec_q  <= wr_val;
        A_MIN:   min_q  <= wr_val;
        A_HOUR:  hour_q <= wr_val;
        A_DATE:  date_q <= wr_val;
        A_MON:   mon_q  <= wr_val;
        A_DOW:   dow_q  <= wr_val;
        A_YEAR:  year_q <= wr_val;
        default: ;
      endcase
    end else begin
      if (adv)    sec_q  <= c_min ? 8'h00 : bcd_inc({1'b0, sec_q[6:0]});
      if (c_min)  min_q  <= c_hour ? 8'h00 : bcd_inc(min_q);
      if (c_hour) hour_q <= hour_nxt;
      if (c_day) begin
        date_q <= c_mon ? 8'h01 : bcd_inc(date_q);
        dow_q  <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
      end
      if (c_mon)  mon_q  <= c_year ? 8'h01 : bcd_inc(mon_q);
      if (c_year) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_data_o = sec_q;
      A_MIN:   rd_data_o = min_q;
      A_HOUR:  rd_data_o = hour_q;
      A_DATE:  rd_data_o = date_q;
      A_MON:   rd_data_o = mon_q;
      A_DOW:   rd_data_o = dow_q;
      A_YEAR:  rd_data_o = year_q;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import bcd_rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] sec_q,
  input logic [DATA_W-1:0] min_q,
  input logic [DATA_W-1:0] hour_q,
  input logic [DATA_W-1:0] date_q,
  input logic [DATA_W-1:0] mon_q,
  input logic [DATA_W-1:0] dow_q,
  input logic [DATA_W-1:0] year_q
);
  logic go;
  assign go = tick_i && !wr_en_i && !sec_q[7];

  p_halt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && sec_q[7]) |=>
      ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(date_q)
       && $stable(mon_q) && $stable(dow_q) && $stable(year_q)));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=>
      ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(date_q)
       && $stable(mon_q) && $stable(dow_q) && $stable(year_q)));

  p_wr_priority_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != A_SEC) |=> $stable(sec_q));

  p_unused_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd7) |=>
      ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(date_q)
       && $stable(mon_q) && $stable(dow_q) && $stable(year_q)));

  p_sec_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && sec_q[6:0] == 7'h59) |=> (sec_q == 8'h00 && min_q != $past(min_q)));

  p_ampm_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && sec_q[6:0] == 7'h59 && min_q == 8'h59 && hour_q[7] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5]) && hour_q[4:0] == 5'h12));
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .sec_q     (sec_q),
  .min_q     (min_q),
  .hour_q    (hour_q),
  .date_q    (date_q),
  .mon_q     (mon_q),
  .dow_q     (dow_q),
  .year_q    (year_q)
);

// File: tb/bcd_rtc_tb_top.sv
`timescale 1ns/100ps
module bcd_rtc_tb_top;
  localparam real CLK_PERIOD = 10.0;
  localparam int  N_RAND     = 4000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_r [7];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bcd_rtc dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  function automatic int bcd2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(input int v);
    logic [3:0] t, u;
    t = 4'(v / 10);
    u = 4'(v % 10);
    return {t, u};
  endfunction

  function automatic logic [7:0] mask_of(input int a);
    case (a)
      0: return 8'hFF; 1: return 8'h7F; 2: return 8'hBF; 3: return 8'h3F;
      4: return 8'h1F; 5: return 8'h07; 6: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // binary reference model of one accepted second
  task automatic model_tick();
    int s, m, h, d, mo, y, dw, dim;
    logic pm, carry;
    if (exp_r[0][7]) return;
    s = bcd2i({1'b0, exp_r[0][6:0]}) + 1;
    if (s < 60) begin exp_r[0] = i2bcd(s); return; end
    exp_r[0] = 8'h00;
    m = bcd2i(exp_r[1]) + 1;
    if (m < 60) begin exp_r[1] = i2bcd(m); return; end
    exp_r[1] = 8'h00;
    if (exp_r[2][7]) begin
      h = bcd2i({3'b000, exp_r[2][4:0]});
      pm = exp_r[2][5];
      carry = 1'b0;
      if (h == 11) begin h = 12; pm = !pm; carry = !pm; end
      else if (h == 12) h = 1;
      else h = h + 1;
      exp_r[2] = 8'h80 | (pm ? 8'h20 : 8'h00) | i2bcd(h);
    end else begin
      h = bcd2i({2'b00, exp_r[2][5:0]}) + 1;
      carry = (h == 24);
      if (carry) h = 0;
      exp_r[2] = i2bcd(h);
    end
    if (!carry) return;
    dw = bcd2i(exp_r[5]);
    exp_r[5] = (dw >= 7) ? 8'h01 : i2bcd(dw + 1);
    d  = bcd2i(exp_r[3]);
    mo = bcd2i(exp_r[4]);
    y  = bcd2i(exp_r[6]);
    case (mo)
      2: dim = (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: dim = 30;
      default: dim = 31;
    endcase
    if (d >= dim) begin
      d = 1;
      if (mo >= 12) begin mo = 1; y = (y + 1) % 100; end
      else mo = mo + 1;
    end else d = d + 1;
    exp_r[3] = i2bcd(d);
    exp_r[4] = i2bcd(mo);
    exp_r[6] = i2bcd(y);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] e;
    for (int a = 0; a < 8; a++) begin
      rd_addr_i = 3'(a);
      #0.4;
      e = (a == 7) ? 8'h00 : exp_r[a];
      n_checks++;
      if (rd_data_o !== e) begin
        n_fail++;
        $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data_o, e);
      end
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic t, input logic w, input int a, input logic [7:0] d,
                      input string tag);
    tick_i = t; wr_en_i = w; wr_addr_i = 3'(a); wr_data_i = d;
    @(posedge clk_i);
    #1;
    tick_i = 1'b0; wr_en_i = 1'b0;
    if (w) begin
      if (a != 7) exp_r[a] = d & mask_of(a);
    end else if (t) model_tick();
    check_all(tag);
    @(negedge clk_i);
  endtask

  task automatic load(input logic [7:0] s, m, h, d, mo, dw, y);
    step(0, 1, 0, s,  "R2"); step(0, 1, 1, m,  "R2"); step(0, 1, 2, h, "R2");
    step(0, 1, 3, d,  "R2"); step(0, 1, 4, mo, "R2"); step(0, 1, 5, dw, "R2");
    step(0, 1, 6, y,  "R2");
  endtask

  function automatic logic [7:0] rand_val(input int a);
    int v;
    case (a)
      0: begin
        v = ($urandom % 2 == 0) ? 55 + int'($urandom % 5) : int'($urandom % 60);
        return {($urandom % 8 == 0), i2bcd(v)[6:0]};
      end
      1: begin
        v = ($urandom % 2 == 0) ? 55 + int'($urandom % 5) : int'($urandom % 60);
        return i2bcd(v);
      end
      2: begin
        if ($urandom % 2 == 0)
          return 8'h80 | (($urandom % 2 == 0) ? 8'h20 : 8'h00) | i2bcd(1 + int'($urandom % 12));
        return i2bcd(int'($urandom % 24));
      end
      3: return i2bcd(($urandom % 3 == 0) ? 28 + int'($urandom % 4) : 1 + int'($urandom % 31));
      4: return i2bcd(1 + int'($urandom % 12));
      5: return i2bcd(1 + int'($urandom % 7));
      6: return i2bcd(int'($urandom % 100));
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1380));
    exp_r = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    #(CLK_PERIOD * 2.5);
    check_all("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");

    // R2: masks on all-ones writes, address 7 ignored
    for (int a = 0; a < 8; a++) step(0, 1, a, 8'hFF, "R2 mask");
    step(0, 1, 7, 8'h5A, "R2 addr7");

    // R10: idle cycles
    load(8'h10, 8'h20, 8'h05, 8'h10, 8'h03, 8'h02, 8'h24);
    step(0, 0, 0, 8'h00, "R10");
    step(0, 0, 0, 8'h00, "R10");

    // R3 seconds / minutes carries
    step(1, 0, 0, 8'h00, "R3");
    load(8'h59, 8'h58, 8'h05, 8'h10, 8'h03, 8'h02, 8'h24);
    step(1, 0, 0, 8'h00, "R3 sec wrap");
    load(8'h59, 8'h59, 8'h05, 8'h10, 8'h03, 8'h02, 8'h24);
    step(1, 0, 0, 8'h00, "R3 min wrap");

    // R5 / R8 full rollover
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99);
    step(1, 0, 0, 8'h00, "R5 R8 year wrap");

    // R6 12-hour transitions
    load(8'h59, 8'h59, 8'hB1, 8'h15, 8'h06, 8'h03, 8'h10);
    step(1, 0, 0, 8'h00, "R6 pm to am");
    load(8'h59, 8'h59, 8'h91, 8'h15, 8'h06, 8'h03, 8'h10);
    step(1, 0, 0, 8'h00, "R6 am to pm");
    load(8'h59, 8'h59, 8'hB2, 8'h15, 8'h06, 8'h03, 8'h10);
    step(1, 0, 0, 8'h00, "R6 12 to 01");

    // R7 month lengths
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01, 8'h24);
    step(1, 0, 0, 8'h00, "R7 leap 28");
    load(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h01, 8'h24);
    step(1, 0, 0, 8'h00, "R7 leap 29");
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01, 8'h23);
    step(1, 0, 0, 8'h00, "R7 non-leap");
    load(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h01, 8'h23);
    step(1, 0, 0, 8'h00, "R7 april");
    load(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h06, 8'h23);
    step(1, 0, 0, 8'h00, "R7 may 30");

    // R4 halt
    step(0, 1, 0, 8'hB0, "R4 set halt");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h00, "R4 halted");
    step(0, 1, 0, 8'h30, "R4 clear halt");
    step(1, 0, 0, 8'h00, "R4 running");

    // R9 write with tick
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h99);
    step(1, 1, 3, 8'h12, "R9");
    step(1, 1, 7, 8'h00, "R9 addr7");

    for (int i = 0; i < N_RAND; i++) begin
      int r, a;
      r = int'($urandom % 100);
      if (r < 12) begin
        a = int'($urandom % 8);
        step(($urandom % 2 == 0), 1, a, rand_val(a), "R9 R2 random");
      end else begin
        step((r < 80), 0, 0, 8'h00, "R3 R5 R6 R7 R8 R10 random");
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule